// File: doc/BRIEF.md
# FIFO Output Bus-Width Matcher

This block sits between the read side of a 36-bit first-word-fall-through FIFO and an output port. The port can be a full 36 bits wide, or it can be narrowed to 18 or 9 bits. When the port is narrow, each FIFO word goes out over two or four port reads. The pieces come out with either the most significant piece first or the least significant piece first. The FIFO head word is popped only when its last piece is read. Until then the word stays at the head of the FIFO, so the block needs no holding register for it.

Three mode pins set the width and the order: a narrowing enable, a byte/word select and an order select. The block samples them on every clock while reset is held. The value present at reset release is then kept until the next reset. Pin changes during operation have no effect. The narrow piece is always placed in the least significant bits of the port bus, and the unused upper bits are driven to zero.

Top module: `bwm_top`

## Requirements
- R1: With the narrowing enable (`cfg_narrow`) low at reset release, the port is 36 bits wide. `port_data` equals `fifo_word`, and every read of a non-empty port pops the FIFO in the same cycle.
- R2: With `cfg_narrow` high and `cfg_byte` low, word mode applies. Each FIFO word is delivered as two 18-bit pieces, and `fifo_pop` fires only on the second read.
- R3: With `cfg_narrow` high and `cfg_byte` high, byte mode applies. Each FIFO word is delivered as four 9-bit pieces, and `fifo_pop` fires only on the fourth read.
- R4: With `cfg_msb_first` high, pieces go out from the most significant to the least significant (bits 35:18 then 17:0; or 35:27, 26:18, 17:9, 8:0). With it low, the order is reversed.
- R5: In a narrow mode the piece occupies `port_data` bits [17:0] or [8:0], and all higher bits of `port_data` read zero.
- R6: The mode pins are sampled only while `rst_n` is low. Changing them after reset release alters neither the width nor the order.
- R7: `fifo_pop` is high only in a cycle with `rd_en` high, `fifo_empty` low and the last piece of the current word on the port.
- R8: `port_empty` is high exactly when the FIFO is empty. A read while the port is empty neither pops nor advances the piece position.
- R9: After reset, the first read of a word returns its first piece in the configured order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the mode pins are sampled while it is low |
| cfg_narrow | input | 1 | Mode pin: enables narrowing of the port |
| cfg_byte | input | 1 | Mode pin: 1 selects 9-bit pieces, 0 selects 18-bit pieces |
| cfg_msb_first | input | 1 | Mode pin: 1 sends the most significant piece first |
| fifo_word | input | 36 | Head word of the FIFO (first-word-fall-through) |
| fifo_empty | input | 1 | FIFO has no word |
| rd_en | input | 1 | Port read request |
| fifo_pop | output | 1 | Removes the FIFO head word this cycle |
| port_data | output | 36 | Current piece, right-aligned and zero-extended |
| port_empty | output | 1 | No piece is available on the port |

## Verification
The bench targets the turn-over from the last piece of one word to the first piece of the next. A design with an off-by-one position counter would pop one read early or late, and the piece sequence would then slip against the reference queue. Both piece orders are run in both narrow modes. A swapped index would show up as mirrored pieces. Reads during empty stretches and gaps in `rd_en` are mixed in, so a counter that advanced on an empty read would start the next word mid-way. The mode pins are flipped after reset release, so a design that followed the live pins would change width in the middle of the stream.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
   typedef enum logic [1:0] {
      BW_FULL    = 2'd0,
      BW_HALF    = 2'd1,
      BW_QUARTER = 2'd2
   } bw_mode_t;

   function automatic logic [1:0] last_index(input bw_mode_t m);
      case (m)
         BW_HALF:    return 2'd1;
         BW_QUARTER: return 2'd3;
         default:    return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/bwm_cfg_latch.sv
module bwm_cfg_latch
   import bwm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     narrow_pin,
   input  logic     byte_pin,
   input  logic     msb_pin,
   output bw_mode_t mode,
   output logic     msb_first
);
   bw_mode_t pin_mode;

   always_comb begin
      if (!narrow_pin)   pin_mode = BW_FULL;
      else if (byte_pin) pin_mode = BW_QUARTER;
      else               pin_mode = BW_HALF;
   end

   // Sample continuously during reset; the value at release is kept.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= pin_mode;
         msb_first <= msb_pin;
      end
   end
endmodule

// File: rtl/bwm_piece_ctr.sv
module bwm_piece_ctr
   import bwm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  bw_mode_t   mode,
   input  logic       advance,
   output logic [1:0] idx,
   output logic       last
);
   assign last = (idx == last_index(mode));

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= 2'd0;
      else if (advance)
         idx <= last ? 2'd0 : idx + 2'd1;
   end
endmodule

// File: rtl/bwm_lane_mux.sv
module bwm_lane_mux
   import bwm_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic [WORD_W-1:0] word,
   input  bw_mode_t          mode,
   input  logic              msb_first,
   input  logic [1:0]        idx,
   output logic [WORD_W-1:0] data
);
   localparam int LANES  = 4;
   localparam int LANE_W = WORD_W / LANES;
   localparam int HALF_W = 2 * LANE_W;

   logic [LANE_W-1:0] lane [LANES];
   logic [HALF_W-1:0] half [2];

   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         assign lane[g] = word[g*LANE_W +: LANE_W];
      end
      for (g = 0; g < 2; g++) begin : g_half
         assign half[g] = word[g*HALF_W +: HALF_W];
      end
   endgenerate

   logic [1:0] q_sel;
   logic       h_sel;
   assign q_sel = msb_first ? (2'd3 - idx) : idx;
   assign h_sel = msb_first ? ~idx[0] : idx[0];

   always_comb begin
      data = '0;
      case (mode)
         BW_HALF:    data[HALF_W-1:0] = half[h_sel];
         BW_QUARTER: data[LANE_W-1:0] = lane[q_sel];
         default:    data = word;
      endcase
   end
endmodule

// File: rtl/bwm_top.sv
module bwm_top
   import bwm_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_narrow,
   input  logic              cfg_byte,
   input  logic              cfg_msb_first,
   input  logic [WORD_W-1:0] fifo_word,
   input  logic              fifo_empty,
   input  logic              rd_en,
   output logic              fifo_pop,
   output logic [WORD_W-1:0] port_data,
   output logic              port_empty
);
   generate
      if (WORD_W % 4 != 0 || WORD_W < 4) begin : g_bad_width
         $error("bwm_top: WORD_W must be a positive multiple of 4");
      end
   endgenerate

   bw_mode_t   cur_mode;
   logic       msb_first;
   logic [1:0] piece_idx;
   logic       piece_last;
   logic       advance;

   assign advance    = rd_en & ~fifo_empty;
   assign fifo_pop   = advance & piece_last;
   assign port_empty = fifo_empty;

   bwm_cfg_latch u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .narrow_pin (cfg_narrow),
      .byte_pin   (cfg_byte),
      .msb_pin    (cfg_msb_first),
      .mode       (cur_mode),
      .msb_first  (msb_first)
   );

   bwm_piece_ctr u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (cur_mode),
      .advance (advance),
      .idx     (piece_idx),
      .last    (piece_last)
   );

   bwm_lane_mux #(.WORD_W(WORD_W)) u_mux (
      .word      (fifo_word),
      .mode      (cur_mode),
      .msb_first (msb_first),
      .idx       (piece_idx),
      .data      (port_data)
   );
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker
   import bwm_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input bw_mode_t          cur_mode,
   input logic              fifo_empty,
   input logic              rd_en,
   input logic              fifo_pop,
   input logic              port_empty,
   input logic [WORD_W-1:0] fifo_word,
   input logic [WORD_W-1:0] port_data
);
   localparam int LANE_W = WORD_W / 4;

   logic [2:0] reads_since_pop;
   always_ff @(posedge clk) begin
      if (!rst_n)
         reads_since_pop <= 3'd0;
      else if (rd_en && !fifo_empty)
         reads_since_pop <= fifo_pop ? 3'd0 : reads_since_pop + 3'd1;
   end

   AST_FULL_POPS_EACH_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == BW_FULL && rd_en && !fifo_empty) |-> (fifo_pop && port_data == fifo_word)); // R1
   AST_HALF_POP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == BW_HALF && fifo_pop) |-> reads_since_pop == 3'd1); // R2
   AST_QUARTER_POP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == BW_QUARTER && fifo_pop) |-> reads_since_pop == 3'd3); // R3
   AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == BW_QUARTER) |-> port_data[WORD_W-1:LANE_W] == '0); // R5
   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(cur_mode)); // R6
   AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (rd_en && !fifo_empty)); // R7
   AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      port_empty |-> !fifo_pop); // R8
endmodule

bind bwm_top bwm_checker #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cur_mode   (cur_mode),
   .fifo_empty (fifo_empty),
   .rd_en      (rd_en),
   .fifo_pop   (fifo_pop),
   .port_empty (port_empty),
   .fifo_word  (fifo_word),
   .port_data  (port_data)
);

// File: tb/bwm_top_tb.sv
`timescale 1ns/1ps
module bwm_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_msb_first = 1'b0;
   logic [35:0] fifo_word = '0;
   logic        fifo_empty = 1'b1;
   logic        rd_en = 1'b0;
   logic        fifo_pop;
   logic [35:0] port_data;
   logic        port_empty;

   always #5 clk = ~clk;

   bwm_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte),
      .cfg_msb_first(cfg_msb_first), .fifo_word(fifo_word), .fifo_empty(fifo_empty),
      .rd_en(rd_en), .fifo_pop(fifo_pop), .port_data(port_data), .port_empty(port_empty)
   );

   // Reference model state
   logic [35:0] q[$];
   int  m_pieces = 1;
   bit  m_msb = 0;
   int  m_idx = 0;
   int  n_checks = 0, n_fail = 0;
   bit  done = 0;

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] exp_piece();
      int w = 36 / m_pieces;
      int k = m_msb ? (m_pieces - 1 - m_idx) : m_idx;
      logic [35:0] mask = (m_pieces == 1) ? '1 : ((36'd1 << w) - 36'd1);
      return (q[0] >> (k * w)) & mask;
   endfunction

   // One clock: drive at negedge, compare, then update model after posedge.
   task automatic step(input bit rd, input string req);
      bit nonempty;
      bit exp_pop;
      @(negedge clk);
      rd_en = rd;
      nonempty = (q.size() != 0);
      fifo_empty = !nonempty;
      fifo_word = nonempty ? q[0] : 36'h0;
      #1;
      chk(port_empty == !nonempty, {req, "/R8 empty"}, 36'(port_empty), 36'(!nonempty));
      exp_pop = rd && nonempty && (m_idx == m_pieces - 1);
      chk(fifo_pop == exp_pop, {req, "/R7 pop"}, 36'(fifo_pop), 36'(exp_pop));
      if (nonempty)
         chk(port_data == exp_piece(), {req, " data"}, port_data, exp_piece());
      @(posedge clk);
      if (rd && nonempty) begin
         if (m_idx == m_pieces - 1) begin
            m_idx = 0;
            void'(q.pop_front());
         end else m_idx++;
      end
   endtask

   task automatic do_reset(input bit nar, input bit byt, input bit msb);
      @(negedge clk);
      rd_en = 0;
      rst_n = 0;
      cfg_narrow = nar; cfg_byte = byt; cfg_msb_first = msb;
      q.delete();
      fifo_empty = 1; fifo_word = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      m_pieces = !nar ? 1 : (byt ? 4 : 2);
      m_msb = msb;
      m_idx = 0;
      // R6: flip every mode pin after release; the model keeps the latched values
      cfg_narrow = !nar; cfg_byte = !byt; cfg_msb_first = !msb;
      #1;
      chk(port_empty == 1'b1, "R9 reset empty", 36'(port_empty), 36'd1);
      chk(fifo_pop == 1'b0, "R9 reset pop", 36'(fifo_pop), 36'd0);
   endtask

   task automatic push_words(input int n, input logic [35:0] seed);
      for (int i = 0; i < n; i++) q.push_back(seed + 36'h1_1111_1111 * i + 36'(i * 7));
   endtask

   task automatic run_stream(input string req);
      // empty reads first (R8: must not advance), then a stream with gaps
      step(1, req); step(1, req);
      push_words(5, 36'h9_8765_4321);
      for (int c = 0; c < 30; c++) step((c % 5) != 3, req);
      for (int c = 0; c < 6; c++) step(1, req);
      push_words(2, 36'hF_0F0F_A5C3);
      for (int c = 0; c < 12; c++) step(c != 1, req);
   endtask

   initial begin
      do_reset(0, 0, 1); run_stream("R1");          // full width
      do_reset(1, 0, 1); run_stream("R2 R4 msb");   // word, MSB first
      do_reset(1, 0, 0); run_stream("R2 R4 lsb");   // word, LSB first
      do_reset(1, 1, 1); run_stream("R3 R4 R5 msb");// byte, MSB first
      do_reset(1, 1, 0); run_stream("R3 R5 R6 lsb");// byte, LSB first
      do_reset(1, 0, 0); run_stream("R6 R9");       // pins flipped to byte/msb after release
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule